// File: doc/BRIEF.md
# Key-Locked Scrambling RAM

This block is a small synchronous RAM whose write and read paths each pass through a bank of per-bit locking cells. Every data lane has its own two-bit key. One key value makes the lane's cell a pass-through and the other makes it an inverter. Host write data is transformed by the write-side bank before it reaches the array, so the array only ever holds scrambled words.

Words leaving the array go through a second bank driven by independent read-side keys. The written word comes back intact only when each read lane key equals the write lane key used when that word was stored. A lane whose legal keys differ returns exactly the inverse of the written bit. The two remaining key codes are treated as illegal. A lane given an illegal code produces 0, and a sticky error flag is raised.

The array is written so that a block RAM with a registered read port can be inferred. Reads have one cycle of latency. A read and a write to the same address in the same cycle return the old contents.

Top module: `lock_ram`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `rd_data` is 0 and `key_error` is 0.
- R2: Lane i of a key vector occupies bits [2i+1:2i]; the upper bit is the inverting-side key and the lower bit the passing-side key, so code 2'b10 inverts the lane and 2'b01 passes it unchanged.
- R3: A word written under write key W and read back with read key W returns the written data.
- R4: When a lane's legal read key differs from the legal write key used for the stored word, that lane returns the inverted written bit, and every other matched lane is unaffected.
- R5: The array stores the write-side transformed word: reading with all lanes set to pass returns the written data with every write-inverted lane flipped.
- R6: `rd_data` changes only in the cycle after a clock edge with `rd_en`=1 and holds its value while `rd_en` is 0, whatever the address and read keys do.
- R7: Keys take effect only at the clock edge of the access that uses them; changing write keys with `we`=0 leaves stored data untouched.
- R8: A write lane given an illegal code (2'b00 or 2'b11) stores 0 in that lane.
- R9: A read lane given an illegal code returns 0 in that lane.
- R10: `key_error` becomes 1 in the cycle after an edge where a write (`we`=1) or a read (`rd_en`=1) uses any illegal lane code, stays 1 until reset, and is not set by illegal codes on an idle port.
- R11: With `we`=0, the write address and data have no effect on the array.
- R12: A read and a write to the same address at the same edge return the contents held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| we | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Host write word |
| wr_key | input | 2*DATA_W | Write-side lane keys |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read word address |
| rd_key | input | 2*DATA_W | Read-side lane keys |
| rd_data | output | DATA_W | Unlocked read word, valid one cycle after the read |
| key_error | output | 1 | Sticky flag for an access with an illegal lane code |

## Verification
The bench flips one lane key at a time against a stored word. A design that confused the lane-to-bit mapping or handled mismatched lanes wrongly would then return the wrong bit or a corrupted neighbour. It reads with all-pass keys to expose the raw array contents, which a design applying keys only at the read side would fail. It also drives illegal codes on an idle port, on a read lane and on a write lane. A flag that is not sticky, or that is raised without an access, would show up there, as would a lane that leaks data instead of 0. Same-address read/write collisions and idle cycles with changing read keys catch a write-first array or an output that follows the live keys.

// File: rtl/lock_ram_pkg.sv
package lock_ram_pkg;

  // Lane key codes: upper bit drives the inverting side, lower bit the passing side.
  typedef enum logic [1:0] {
    LK_DEAD0 = 2'b00,
    LK_PASS  = 2'b01,
    LK_INV   = 2'b10,
    LK_DEAD1 = 2'b11
  } lane_key_e;

  localparam logic [1:0] LANE_PASS = 2'b01;
  localparam logic [1:0] LANE_INV  = 2'b10;

endpackage

// File: rtl/lock_cell_bank.sv
module lock_cell_bank
  import lock_ram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [2*LANES-1:0] key,
  input  logic [LANES-1:0]   din,
  output logic [LANES-1:0]   dout,
  output logic [LANES-1:0]   lane_bad
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_key_e code;
    assign code = lane_key_e'(key[2*g+1 -: 2]);

    always_comb begin
      case (code)
        LK_PASS: begin
          dout[g]     = din[g];
          lane_bad[g] = 1'b0;
        end
        LK_INV: begin
          dout[g]     = ~din[g];
          lane_bad[g] = 1'b0;
        end
        default: begin
          dout[g]     = 1'b0;
          lane_bad[g] = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/lock_ram_array.sv
module lock_ram_array #(
  parameter int DATA_W = 4,
  parameter int DEPTH  = 4,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_word,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Storage: no reset, so a block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (we) mem[wr_addr] <= wr_word;
  end

  // Registered read port, read-before-write on collisions.
  always_ff @(posedge clk) begin
    if (rst)        rd_word <= '0;
    else if (rd_en) rd_word <= mem[rd_addr];
  end

endmodule

// File: rtl/lock_ram.sv
module lock_ram
  import lock_ram_pkg::*;
#(
  parameter int DATA_W = 4,
  parameter int DEPTH  = 4,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int KEY_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [KEY_W-1:0]  wr_key,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [KEY_W-1:0]  rd_key,
  output logic [DATA_W-1:0] rd_data,
  output logic              key_error
);

  localparam logic [KEY_W-1:0] KEY_ALL_PASS = {DATA_W{LANE_PASS}};

  logic [DATA_W-1:0] wr_locked;
  logic [DATA_W-1:0] wr_bad;
  logic [DATA_W-1:0] arr_word;
  logic [KEY_W-1:0]  rd_key_q;
  logic [DATA_W-1:0] rd_bad;
  logic              bad_access;

  // Write-side cells scramble host data before storage.
  lock_cell_bank #(.LANES(DATA_W)) u_wr_cells (
    .key      (wr_key),
    .din      (wr_data),
    .dout     (wr_locked),
    .lane_bad (wr_bad)
  );

  lock_ram_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_array (
    .clk     (clk),
    .rst     (rst),
    .we      (we),
    .wr_addr (wr_addr),
    .wr_word (wr_locked),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_word (arr_word)
  );

  // Read keys are captured alongside the read so both belong to the same edge.
  always_ff @(posedge clk) begin
    if (rst)        rd_key_q <= KEY_ALL_PASS;
    else if (rd_en) rd_key_q <= rd_key;
  end

  lock_cell_bank #(.LANES(DATA_W)) u_rd_cells (
    .key      (rd_key_q),
    .din      (arr_word),
    .dout     (rd_data),
    .lane_bad (rd_bad)
  );

  // Illegal read codes are judged on the live key so the flag aligns with the data.
  always_comb begin
    bad_access = we && (|wr_bad);
    for (int i = 0; i < DATA_W; i++) begin
      if (rd_en && (rd_key[2*i+1] == rd_key[2*i])) bad_access = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             key_error <= 1'b0;
    else if (bad_access) key_error <= 1'b1;
  end

  logic unused_rd_bad;
  assign unused_rd_bad = ^rd_bad;

endmodule

// File: rtl/lock_ram_chk.sv
module lock_ram_chk #(
  parameter int DATA_W = 4,
  localparam int KEY_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic              we,
  input logic [KEY_W-1:0]  wr_key,
  input logic              rd_en,
  input logic [KEY_W-1:0]  rd_key,
  input logic [DATA_W-1:0] rd_data,
  input logic              key_error
);

  function automatic logic has_dead(input logic [KEY_W-1:0] k);
    logic r = 1'b0;
    for (int i = 0; i < DATA_W; i++) if (k[2*i+1] == k[2*i]) r = 1'b1;
    return r;
  endfunction

  logic trig;
  assign trig = (we && has_dead(wr_key)) || (rd_en && has_dead(rd_key));

  // R10: flag stays up until reset
  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    key_error |=> key_error);

  // R10: illegal code on an active access raises the flag
  a_r10_raise: assert property (@(posedge clk) disable iff (rst)
    trig |=> key_error);

  // R10: flag never rises without an offending access
  a_r10_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(key_error) |-> $past(trig));

  // R6: output holds across idle read cycles
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(rd_en)) |-> $stable(rd_data));

  // R9: all read lanes dead yields an all-zero word
  a_r9_dead_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_key == '0) |=> rd_data == '0);

endmodule

bind lock_ram lock_ram_chk #(.DATA_W(DATA_W)) u_lock_ram_chk (
  .clk       (clk),
  .rst       (rst),
  .we        (we),
  .wr_key    (wr_key),
  .rd_en     (rd_en),
  .rd_key    (rd_key),
  .rd_data   (rd_data),
  .key_error (key_error)
);

// File: tb/test_lock_ram.sv
module test_lock_ram;

  localparam int DW = 4;
  localparam int DEPTH = 4;
  localparam int AW = 2;
  localparam int KW = 2 * DW;
  localparam logic [KW-1:0] PASS_ALL = 8'h55;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic we = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [KW-1:0] wr_key = PASS_ALL;
  logic rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [KW-1:0] rd_key = PASS_ALL;
  logic [DW-1:0] rd_data;
  logic key_error;

  int checks = 0;
  int failures = 0;

  logic [DW-1:0] exp_q [$];
  string tag_q [$];
  logic [DW-1:0] mdl [DEPTH];
  logic [DW-1:0] last_rd;
  logic ke_exp;

  always #10 clk = ~clk;

  lock_ram #(.DATA_W(DW), .DEPTH(DEPTH)) i_lock_ram (
    .clk(clk), .rst(rst), .we(we), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_key(wr_key), .rd_en(rd_en), .rd_addr(rd_addr), .rd_key(rd_key),
    .rd_data(rd_data), .key_error(key_error)
  );

  // Requirement-level transform: 01 pass, 10 invert, other codes give 0.
  function automatic logic [DW-1:0] xform(input logic [KW-1:0] k, input logic [DW-1:0] d);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) begin
      case (k[2*i+1 -: 2])
        2'b01:   r[i] = d[i];
        2'b10:   r[i] = ~d[i];
        default: r[i] = 1'b0;
      endcase
    end
    return r;
  endfunction

  function automatic logic dead(input logic [KW-1:0] k);
    logic r = 1'b0;
    for (int i = 0; i < DW; i++) if (k[2*i+1] == k[2*i]) r = 1'b1;
    return r;
  endfunction

  function automatic logic [KW-1:0] rand_key();
    logic [KW-1:0] k;
    for (int i = 0; i < DW; i++) k[2*i+1 -: 2] = ($urandom % 2 == 0) ? 2'b01 : 2'b10;
    return k;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus; reads push their expected word.
  task automatic acc(input logic w, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                     input logic [KW-1:0] wk, input logic r, input logic [AW-1:0] ra,
                     input logic [KW-1:0] rk, input string tag,
                     input bit has_exp, input logic [DW-1:0] exp_in);
    @(negedge clk);
    we = w; wr_addr = wa; wr_data = wd; wr_key = wk;
    rd_en = r; rd_addr = ra; rd_key = rk;
    if (r) begin
      last_rd = has_exp ? exp_in : xform(rk, mdl[ra]);
      exp_q.push_back(last_rd);
      tag_q.push_back(tag);
    end
    if ((w && dead(wk)) || (r && dead(rk))) ke_exp = 1'b1;
    if (w) mdl[wa] = xform(wk, wd);
  endtask

  task automatic idle(input logic [KW-1:0] wk, input logic [KW-1:0] rk);
    acc(1'b0, 2'd3, 4'hF, wk, 1'b0, 2'd3, rk, "", 1'b0, '0);
  endtask

  // Monitor: pops the scoreboard after each read edge.
  always @(posedge clk) begin
    if (!rst && rd_en) begin
      #5;
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL scoreboard: actual=%b expected=none", rd_data);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; we = 1'b0; rd_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 rd_data in reset", rd_data, '0);
    check("R1 key_error in reset", {3'b0, key_error}, '0);
    rst = 1'b0;
    ke_exp = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    ke_exp = 1'b0;
    for (int a = 0; a < DEPTH; a++) mdl[a] = '0;
    do_reset();
    @(negedge clk);
    check("R1 rd_data after reset", rd_data, '0);
    check("R1 key_error after reset", {3'b0, key_error}, '0);

    // R2: lane 0 inverts, others pass; raw read shows bit 0 flipped.
    acc(1'b1, 2'd0, 4'b1010, 8'b01_01_01_10, 1'b0, 2'd0, PASS_ALL, "", 1'b0, '0);
    acc(1'b0, 2'd0, 4'h0, PASS_ALL, 1'b1, 2'd0, PASS_ALL, "R2 lane encoding", 1'b1, 4'b1011);

    // R3, R5, R4 under random legal keys.
    for (int round = 0; round < 3; round++) begin
      for (int a = 0; a < DEPTH; a++) begin
        logic [DW-1:0] d;
        logic [KW-1:0] wk;
        logic [DW-1:0] inv;
        d = DW'($urandom);
        wk = rand_key();
        for (int i = 0; i < DW; i++) inv[i] = (wk[2*i+1 -: 2] == 2'b10);
        acc(1'b1, AW'(a), d, wk, 1'b0, '0, PASS_ALL, "", 1'b0, '0);
        acc(1'b0, '0, '0, PASS_ALL, 1'b1, AW'(a), wk, "R3 matched keys", 1'b1, d);
        acc(1'b0, '0, '0, PASS_ALL, 1'b1, AW'(a), PASS_ALL, "R5 raw stored word", 1'b1, d ^ inv);
        for (int ln = 0; ln < DW; ln++) begin
          logic [KW-1:0] rk;
          rk = wk;
          rk[2*ln+1 -: 2] = ~wk[2*ln+1 -: 2];
          acc(1'b0, '0, '0, PASS_ALL, 1'b1, AW'(a), rk, "R4 one lane mismatched", 1'b1,
              d ^ DW'(1 << ln));
        end
      end
    end

    // R12: same-address collision returns old contents, then the new word.
    acc(1'b1, 2'd1, 4'h6, PASS_ALL, 1'b1, 2'd1, PASS_ALL, "R12 read-old on collision", 1'b0, '0);
    acc(1'b0, '0, '0, PASS_ALL, 1'b1, 2'd1, PASS_ALL, "R12 new word after", 1'b1, 4'h6);

    // R11 / R7: idle write port with other keys and data leaves the array alone.
    acc(1'b0, 2'd2, 4'h9, 8'hAA, 1'b0, '0, PASS_ALL, "", 1'b0, '0);
    acc(1'b0, 2'd2, 4'h3, 8'h00, 1'b0, '0, PASS_ALL, "", 1'b0, '0);
    acc(1'b0, '0, '0, PASS_ALL, 1'b1, 2'd2, PASS_ALL, "R11 R7 idle write ignored", 1'b0, '0);

    // R6: output holds while read is idle and keys/address change.
    acc(1'b0, '0, '0, PASS_ALL, 1'b1, 2'd1, 8'b01_10_01_10, "R6 read before hold", 1'b0, '0);
    idle(PASS_ALL, 8'hAA);
    idle(PASS_ALL, 8'h00);
    check("R6 hold with rd_en low", rd_data, last_rd);
    check("R10 no flag with legal keys", {3'b0, key_error}, '0);

    // R10: illegal codes on an idle port do not raise the flag.
    idle(8'h00, 8'hFF);
    idle(8'hFF, 8'h00);
    check("R10 idle illegal keys ignored", {3'b0, key_error}, '0);

    // R9: lane 1 dead on read returns 0 there and raises the flag.
    acc(1'b0, '0, '0, PASS_ALL, 1'b1, 2'd1, 8'b01_01_00_01, "R9 dead read lane", 1'b1, 4'h6 & 4'b1101);
    idle(PASS_ALL, PASS_ALL);
    check("R10 flag raised", {3'b0, key_error}, {3'b0, ke_exp});
    idle(PASS_ALL, PASS_ALL);
    idle(PASS_ALL, PASS_ALL);
    check("R10 flag sticky", {3'b0, key_error}, 4'h1);

    // R8: lane 2 dead on write stores 0 there.
    acc(1'b1, 2'd3, 4'hF, 8'b01_11_01_01, 1'b0, '0, PASS_ALL, "", 1'b0, '0);
    acc(1'b0, '0, '0, PASS_ALL, 1'b1, 2'd3, PASS_ALL, "R8 dead write lane", 1'b1, 4'b1011);
    idle(PASS_ALL, PASS_ALL);

    do_reset();
    @(negedge clk);
    check("R1 flag cleared by reset", {3'b0, key_error}, '0);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule